// File: doc/BRIEF.md
# Packed-Lane Shift-Add-Subtract Unit

This unit performs one arithmetic step on a 48-bit word that carries several packed sub-words (lanes). The operation is chosen per cycle: add the two operands, subtract the second from the first, arithmetically shift the first operand right, or pass the first operand through. The lane width is also chosen per cycle and may be 8, 12 or 16 bits, so the word holds six, four or three lanes. The 12-bit width is not a power of two. Shift-and-add steps of this kind are the usual way to apply constant multiplication in signed-digit form to every lane at once.

A protection input sets how lane edges are treated. With protection on, the hardware cuts every carry at the top of a lane and drops every bit that a shift pushes out of the bottom of a lane, so each lane is computed on its own. With protection off, the word is treated as one flat 48-bit number. Keeping lanes apart is then left to software, which places guard bits before the operation. The result is registered by default, and a parameter can make the unit purely combinational.

Top module: `simd_sas_unit`

## Requirements
- R1: `lane_sel` picks the lane width when `prot_en` is 1: 00 gives six 8-bit lanes, 01 gives four 12-bit lanes, 10 gives three 16-bit lanes, and 11 acts the same as 10. Lane k covers bits [k*w+w-1 : k*w].
- R2: `opcode` 00 with `prot_en`=1 puts (A+B) mod 2^w into each lane. A carry out of the top bit of a lane never reaches the lane above it.
- R3: `opcode` 01 with `prot_en`=1 puts (A−B) mod 2^w into each lane, computed as A + ~B + 1 with the +1 applied at the bottom of each lane. No borrow crosses a lane edge.
- R4: `opcode` 10 with `prot_en`=1 shifts each lane of A right arithmetically by `shamt` (0 to 7). Each lane's top bit fills the vacated positions, and bits shifted out of the bottom of a lane are discarded. A shift of 0 returns A unchanged.
- R5: With `prot_en`=0, `opcode` 00 gives (A+B) mod 2^48 and `opcode` 01 gives (A−B) mod 2^48. `lane_sel` has no effect in this mode.
- R6: With `prot_en`=0, `opcode` 10 gives the 48-bit arithmetic right shift of A by `shamt`, filled from bit 47. Bits move across lane edges.
- R7: `opcode` 11 returns A. `op_b`, `shamt`, `lane_sel` and `prot_en` have no effect on it.
- R8: With OUT_REG=1 (the default), `result` shows the value computed from the inputs sampled at a rising clock edge, starting from that edge. While `rst_n` is low, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| op_a | input | 48 | First operand; the operand that is shifted or passed through |
| op_b | input | 48 | Second operand for add and subtract |
| opcode | input | 2 | 00 add, 01 subtract, 10 right shift, 11 pass |
| lane_sel | input | 2 | Lane width: 00 = 8, 01 = 12, 10 and 11 = 16 |
| shamt | input | 3 | Right-shift distance, 0 to 7 |
| prot_en | input | 1 | 1 = lanes isolated in hardware, 0 = flat 48-bit word |
| result | output | 48 | Result of the operation |

## Verification
The assertions check, on every cycle, a set of fixed relations between the inputs and the unregistered result:
- the sum in one 16-bit lane and the difference in the top 8-bit lane;
- that the sign bit is kept under a lane shift;
- the flat 48-bit sum and the flat shift by one;
- pass-through;
- that a carry cut at the top of the lowest 8-bit lane leaves the next lane's bottom bit unaffected.

Whole-word behaviour can only be shown by the bench's scenarios, which compare every lane of every width against a model computed lane by lane. These scenarios cover:
- carries and borrows forced across every edge;
- negative lanes shifted by all distances;
- the alias lane code 11;
- pass-through with noise on the unused inputs;
- the one-cycle register delay and the reset value.

// File: rtl/simd_sas_pkg.sv
package simd_sas_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_SHR  = 2'b10,
    OP_PASS = 2'b11
  } sas_op_e;

  typedef enum logic [1:0] {
    LANE_S  = 2'b00,
    LANE_M  = 2'b01,
    LANE_L  = 2'b10,
    LANE_L2 = 2'b11
  } lane_sel_e;

  // Index of the top bit of the lane that holds bit position pos.
  function automatic int lane_top(int pos, int width);
    return (pos / width) * width + width - 1;
  endfunction

  // True when pos is the lowest bit of its lane.
  function automatic bit lane_bottom(int pos, int width);
    return (pos % width) == 0;
  endfunction

endpackage

// File: rtl/sas_lane_map.sv
module sas_lane_map
  import simd_sas_pkg::*;
#(
  parameter int W    = 48,
  parameter int LW_S = 8,
  parameter int LW_M = 12,
  parameter int LW_L = 16
) (
  input  lane_sel_e      sel,
  input  logic           prot,
  output logic [W-1:0]   lsb_mark,
  output logic [W-1:0]   msb_mark
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam bit BS = lane_bottom(i, LW_S);
    localparam bit BM = lane_bottom(i, LW_M);
    localparam bit BL = lane_bottom(i, LW_L);
    localparam bit TS = (lane_top(i, LW_S) == i);
    localparam bit TM = (lane_top(i, LW_M) == i);
    localparam bit TL = (lane_top(i, LW_L) == i);
    localparam bit BF = (i == 0);
    localparam bit TF = (i == W - 1);

    always_comb begin
      if (!prot) begin
        lsb_mark[i] = BF;
        msb_mark[i] = TF;
      end else begin
        case (sel)
          LANE_S:  begin lsb_mark[i] = BS; msb_mark[i] = TS; end
          LANE_M:  begin lsb_mark[i] = BM; msb_mark[i] = TM; end
          default: begin lsb_mark[i] = BL; msb_mark[i] = TL; end
        endcase
      end
    end
  end
endmodule

// File: rtl/sas_addsub.sv
module sas_addsub #(
  parameter int W = 48
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic [W-1:0] lsb_mark,
  input  logic [W-1:0] msb_mark,
  output logic [W-1:0] sum,
  output logic [W-1:0] lane_cout
);
  logic [W:0]   c;
  logic [W-1:0] b_eff;
  logic [W-1:0] cin;

  assign b_eff = sub ? ~b : b;
  assign c[0]  = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // Chain restarts at each lane bottom with the subtract carry-in.
    assign cin[i]       = lsb_mark[i] ? sub : c[i];
    assign sum[i]       = a[i] ^ b_eff[i] ^ cin[i];
    assign c[i+1]       = (a[i] & b_eff[i]) | (cin[i] & (a[i] ^ b_eff[i]));
    // Carry leaving a lane top: cut here, exposed for checking.
    assign lane_cout[i] = msb_mark[i] & c[i+1];
  end
endmodule

// File: rtl/sas_shift.sv
module sas_shift
  import simd_sas_pkg::*;
#(
  parameter int W    = 48,
  parameter int LW_S = 8,
  parameter int LW_M = 12,
  parameter int LW_L = 16,
  parameter int SH_W = 3
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] sh,
  input  lane_sel_e       sel,
  input  logic            prot,
  output logic [W-1:0]    out
);
  localparam int IDX_W = $clog2(W + (1 << SH_W));

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int HS = lane_top(i, LW_S);
    localparam int HM = lane_top(i, LW_M);
    localparam int HL = lane_top(i, LW_L);

    logic [IDX_W-1:0] hi;
    logic [IDX_W-1:0] src;
    logic             bit_o;

    always_comb begin
      if (!prot) hi = IDX_W'(W - 1);
      else begin
        case (sel)
          LANE_S:  hi = IDX_W'(HS);
          LANE_M:  hi = IDX_W'(HM);
          default: hi = IDX_W'(HL);
        endcase
      end
      src = IDX_W'(i) + IDX_W'(sh);
      // Source past the lane top: replicate lane sign bit.
      if (src > hi) bit_o = a[hi];
      else          bit_o = a[src];
    end

    assign out[i] = bit_o;
  end
endmodule

// File: rtl/simd_sas_unit.sv
module simd_sas_unit
  import simd_sas_pkg::*;
#(
  parameter int W       = 48,
  parameter int LW_S    = 8,
  parameter int LW_M    = 12,
  parameter int LW_L    = 16,
  parameter int SH_W    = 3,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [1:0]      opcode,
  input  logic [1:0]      lane_sel,
  input  logic [SH_W-1:0] shamt,
  input  logic            prot_en,
  output logic [W-1:0]    result
);
  sas_op_e     op;
  lane_sel_e   sel;
  logic [W-1:0] lsb_mark, msb_mark;
  logic [W-1:0] arith_res, shift_res, lane_cout;
  logic [W-1:0] res_next;

  assign op  = sas_op_e'(opcode);
  assign sel = lane_sel_e'(lane_sel);

  sas_lane_map #(.W(W), .LW_S(LW_S), .LW_M(LW_M), .LW_L(LW_L)) u_map (
    .sel(sel), .prot(prot_en), .lsb_mark(lsb_mark), .msb_mark(msb_mark)
  );

  sas_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .sub(op == OP_SUB),
    .lsb_mark(lsb_mark), .msb_mark(msb_mark),
    .sum(arith_res), .lane_cout(lane_cout)
  );

  sas_shift #(.W(W), .LW_S(LW_S), .LW_M(LW_M), .LW_L(LW_L), .SH_W(SH_W)) u_shift (
    .a(op_a), .sh(shamt), .sel(sel), .prot(prot_en), .out(shift_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: res_next = arith_res;
      OP_SHR:         res_next = shift_res;
      default:        res_next = op_a;
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= res_next;
    end
  end else begin : g_comb
    assign result = res_next;
  end

  p_lane_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && op == OP_ADD && sel == LANE_L) |->
      (res_next[31:16] == 16'(op_a[31:16] + op_b[31:16])));

  p_carry_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && op == OP_ADD && sel == LANE_S && lane_cout[7]) |->
      (res_next[8] == (op_a[8] ^ op_b[8])));

  p_lane_diff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && op == OP_SUB && sel == LANE_S) |->
      (res_next[47:40] == 8'(op_a[47:40] - op_b[47:40])));

  p_sign_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && op == OP_SHR && sel == LANE_M) |->
      (res_next[11] == op_a[11] && res_next[47] == op_a[47]));

  p_flat_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en && op == OP_ADD) |-> (res_next == W'(op_a + op_b)));

  p_flat_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en && op == OP_SHR && shamt == 1) |->
      (res_next[W-2:0] == op_a[W-1:1]));

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PASS) |-> (res_next == op_a));

endmodule

// File: tb/tb_simd_sas_unit.sv
module tb_simd_sas_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] op_a = '0, op_b = '0;
  logic [1:0]  opcode = 2'b11, lane_sel = 2'b00;
  logic [2:0]  shamt = '0;
  logic        prot_en = 1'b0;
  logic [47:0] result;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [47:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t sb[$];

  simd_sas_unit dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .lane_sel(lane_sel), .shamt(shamt), .prot_en(prot_en), .result(result)
  );

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // Lane-by-lane reference model derived from the requirements.
  function automatic logic [47:0] model(logic [47:0] a, logic [47:0] b,
      logic [1:0] op, logic [1:0] ls, logic [2:0] sh, logic pr);
    logic [47:0] r;
    int w;
    if (op == 2'b11) return a;
    if (!pr) begin
      case (op)
        2'b00:   return a + b;
        2'b01:   return a - b;
        default: return 48'($signed(a) >>> sh);
      endcase
    end
    w = (ls == 2'b00) ? 8 : (ls == 2'b01) ? 12 : 16;
    r = '0;
    for (int l = 0; l < 48 / w; l++) begin
      longint m, ua, ub, v;
      m  = (longint'(1) << w) - 1;
      ua = longint'(a >> (l * w)) & m;
      ub = longint'(b >> (l * w)) & m;
      case (op)
        2'b00: v = (ua + ub) & m;
        2'b01: v = (ua - ub) & m;
        default: begin
          v = (ua ^ (longint'(1) << (w - 1))) - (longint'(1) << (w - 1));
          v = (v >>> sh) & m;
        end
      endcase
      r = r | (48'(v) << (l * w));
    end
    return r;
  endfunction

  task automatic drive(logic [47:0] a, logic [47:0] b, logic [1:0] op,
                       logic [1:0] ls, logic [2:0] sh, logic pr, string tag);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; lane_sel = ls; shamt = sh; prot_en = pr;
    it.exp = model(a, b, op, ls, sh, pr);
    it.due = cyc + 1;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare registered result one edge after drive.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (result !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, result, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    op_a = 48'hDEAD_BEEF_1234;
    repeat (3) @(negedge clk);
    n_run++;  // R8 reset value
    if (result !== 48'h0) begin
      n_fail++;
      $display("FAIL R8 reset: got %h expected %h", result, 48'h0);
    end
    rst_n = 1'b1;

    // R2 8-bit lanes: carries at every edge must vanish
    drive(48'h80_80_80_80_80_80, 48'h80_80_80_80_80_80, 2'b00, 2'b00, 3'd0, 1'b1, "R2 add8 carry kill");
    drive(48'hFF_01_FF_7F_FF_00, 48'h01_FF_01_01_FF_00, 2'b00, 2'b00, 3'd0, 1'b1, "R2 add8 mixed");
    // R1 / R2 12-bit and 16-bit lanes, lane code 11 alias
    drive(48'hFFF_800_7FF_001, 48'h001_800_001_FFF, 2'b00, 2'b01, 3'd0, 1'b1, "R1 R2 add12");
    drive(48'hFFFF_8000_1234, 48'h0001_8000_EDCC, 2'b00, 2'b10, 3'd0, 1'b1, "R2 add16");
    drive(48'hFFFF_8000_1234, 48'h0001_8000_EDCC, 2'b00, 2'b11, 3'd0, 1'b1, "R1 alias 11");
    // R3 borrows must not cross lanes
    drive(48'h00_00_00_00_00_00, 48'h01_01_01_01_01_01, 2'b01, 2'b00, 3'd0, 1'b1, "R3 sub8 borrow");
    drive(48'h000_123_800_000, 48'h001_124_001_000, 2'b01, 2'b01, 3'd0, 1'b1, "R3 sub12");
    drive(48'h0000_7FFF_0005, 48'h0001_FFFF_0006, 2'b01, 2'b10, 3'd0, 1'b1, "R3 sub16");
    // R4 lane shifts with negative and positive lanes
    drive(48'h80_7F_F0_0F_81_01, '0, 2'b10, 2'b00, 3'd3, 1'b1, "R4 shr8 by3");
    drive(48'h800_7FF_F00_0F1, '0, 2'b10, 2'b01, 3'd5, 1'b1, "R4 shr12 by5");
    drive(48'h8000_7FFF_FFFF, '0, 2'b10, 2'b10, 3'd7, 1'b1, "R4 shr16 by7");
    drive(48'hA5_5A_C3_3C_96_69, '0, 2'b10, 2'b00, 3'd0, 1'b1, "R4 shr by0");
    // R5 / R6 flat word
    drive(48'h80_80_80_80_80_80, 48'h80_80_80_80_80_80, 2'b00, 2'b00, 3'd0, 1'b0, "R5 flat add");
    drive(48'h00_00_00_00_00_00, 48'h00_00_00_00_00_01, 2'b01, 2'b01, 3'd0, 1'b0, "R5 flat sub");
    drive(48'h80_01_01_01_01_01, '0, 2'b10, 2'b00, 3'd4, 1'b0, "R6 flat shr");
    // R7 pass with noise on unused inputs
    drive(48'h0123_4567_89AB, 48'hFFFF_FFFF_FFFF, 2'b11, 2'b01, 3'd7, 1'b1, "R7 pass prot");
    drive(48'h0123_4567_89AB, 48'h5555_5555_5555, 2'b11, 2'b10, 3'd2, 1'b0, "R7 pass flat");

    // Mixed random vectors over every mode (R1..R7, R8 timing)
    for (int k = 0; k < 400; k++) begin
      logic [47:0] ra, rb;
      ra = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      rb = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      drive(ra, rb, 2'($urandom), 2'($urandom), 3'($urandom), 1'($urandom), "R1 R8 random");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule